// File: doc/BRIEF.md
# Memory-to-Memory Add Execute Sequencer

This block carries out the execute phase of a three-word add instruction. The destination uses indexed addressing and the source uses memory-indirect addressing. When `start` is pulsed, the block latches three values that fetch and decode have already produced: the destination base address, the source pointer location and the value of the selected index register. It then makes exactly four accesses, one at a time, on a single-port synchronous memory interface. It reads the pointer, reads the source operand through that pointer, reads the destination operand at base plus index, and writes the sum back to the same place.

The destination effective address comes from a plain register addition, so it costs no memory cycle. Each read holds its address and read enable until the memory returns a read-valid strobe, so the memory may take any number of cycles to answer. The write takes one cycle. At the end the block pulses `done` for one cycle and reports how many memory cycles it used, which is always 4. It also keeps the carry out of the addition as a flag.

Top module: `add_exec_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `done`, `mem_re`, `mem_we` and `carry_flag` are 0 and `mem_cycles` is 0. A reset in the middle of a sequence abandons it without writing memory.
- R2: The destination effective address equals `dst_base + index_val` modulo 2^ADDR_W. Forming it uses no memory access.
- R3: The first access is a read at `src_ptr`.
- R4: The second access is a read at the address held in the low ADDR_W bits of the word returned by the first read. The upper bits of that word are ignored.
- R5: The third access is a read at the destination effective address.
- R6: The fourth access is a write at the destination effective address. Its data is the source operand plus the destination operand, modulo 2^DATA_W.
- R7: `carry_flag` holds the carry out of that addition from the write until the next start. The carry is never written to memory.
- R8: During a read, `mem_re` and `mem_addr` stay constant until `mem_rvalid` is seen high at a clock edge. The sequence then moves on at that edge.
- R9: `mem_we` is high for exactly one cycle per sequence.
- R10: `done` is a one-cycle pulse that follows the write. While `done` is high, `mem_cycles` reads 4. On the next cycle `busy` is 0.
- R11: A `start` pulse while `busy` is high is ignored. It changes neither the addresses nor the number of accesses.
- R12: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a sequence (taken only when idle) |
| dst_base | input | ADDR_W | Destination base address (second instruction word) |
| src_ptr | input | ADDR_W | Location holding the source pointer (third instruction word) |
| index_val | input | ADDR_W | Value of the selected index register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_cycles | output | CNT_W | Memory accesses completed in this sequence |
| carry_flag | output | 1 | Carry out of the last addition |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Read request, held until read valid |
| mem_we | output | 1 | Write enable, one cycle |
| mem_wdata | output | DATA_W | Write data (the sum) |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid strobe |

## Verification
A wrong sequencer state shows up at once on the memory pins. A skipped or repeated state gives the wrong access count or the wrong access order, so the very next strobe or write lands at the wrong address. An error in the effective-address or pointer register stays hidden through the first read. It appears only when the third access or the second access goes to the wrong location. An error in the operand or sum register is visible only in the written data and the carry flag at the end of the sequence. For that reason every run compares the whole access log, the memory contents and the flag, using several read latencies and wrapping cases.

// File: rtl/add_exec_pkg.sv
// Shared definitions for the add execute sequencer.
// Assumes one memory access is outstanding at a time.
package add_exec_pkg;
    // Number of memory accesses in one execute sequence.
    localparam int unsigned N_ACCESS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_SRC,
        ST_DST,
        ST_WR,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/add_exec_ea.sv
// Destination effective-address unit: registers base + index when loaded.
// Assumes the result wraps modulo 2^ADDR_W and needs no memory access.
module add_exec_ea #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    output logic [ADDR_W-1:0] ea
);
    // Capture the wrapped effective address at sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n)    ea <= '0;
        else if (load) ea <= base + index;
    end

    AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ea)); // R11
endmodule

// File: rtl/add_exec_sum.sv
// Operand adder: captures the wrapped sum and carry of two operands.
// Assumes capture happens once per sequence, on the destination read.
module add_exec_sum #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum,
    output logic              carry
);
    logic [DATA_W:0] wide;

    // Full-width add keeps the carry bit apart from the data.
    always_comb wide = {1'b0, op_a} + {1'b0, op_b};

    // Register the sum and carry when the destination operand arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum   <= '0;
            carry <= 1'b0;
        end else if (cap) begin
            sum   <= wide[DATA_W-1:0];
            carry <= wide[DATA_W];
        end
    end

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(sum) && $stable(carry))); // R7
endmodule

// File: rtl/add_exec_fsm.sv
// Access sequencer: pointer read, source read, destination read, write.
// Assumes reads finish on mem_rvalid and writes finish in one cycle.
module add_exec_fsm
    import add_exec_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              load,
    output logic              cap,
    output logic [DATA_W-1:0] src_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  mem_cycles
);
    seq_state_t        state;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] src_addr_q;

    // Advance through the four accesses and count each one completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr_q      <= '0;
            src_addr_q <= '0;
            src_op     <= '0;
            mem_cycles <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ptr_q      <= src_ptr;
                    mem_cycles <= '0;
                    state      <= ST_PTR;
                end
                ST_PTR: if (mem_rvalid) begin
                    src_addr_q <= mem_rdata[ADDR_W-1:0];
                    mem_cycles <= mem_cycles + 1'b1;
                    state      <= ST_SRC;
                end
                ST_SRC: if (mem_rvalid) begin
                    src_op     <= mem_rdata;
                    mem_cycles <= mem_cycles + 1'b1;
                    state      <= ST_DST;
                end
                ST_DST: if (mem_rvalid) begin
                    mem_cycles <= mem_cycles + 1'b1;
                    state      <= ST_WR;
                end
                ST_WR: begin
                    mem_cycles <= mem_cycles + 1'b1;
                    state      <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the memory strobes, the address select and the status lines from the state.
    always_comb begin
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (state)
            ST_PTR: begin mem_re = 1'b1; mem_addr = ptr_q;      end
            ST_SRC: begin mem_re = 1'b1; mem_addr = src_addr_q; end
            ST_DST: begin mem_re = 1'b1; mem_addr = ea;         end
            ST_WR:  begin mem_we = 1'b1; mem_addr = ea;         end
            default: ;
        endcase
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
        load = (state == ST_IDLE) && start;
        cap  = (state == ST_DST) && mem_rvalid;
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !mem_rvalid) |=> (mem_re && $stable(mem_addr))); // R8
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R9
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cycles == CNT_W'(N_ACCESS))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
endmodule

// File: rtl/add_exec_seq.sv
// Top of the add execute sequencer: effective-address unit, access sequencer, adder.
// Assumes the instruction words and the index value are stable when start is pulsed.
module add_exec_seq
    import add_exec_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned CNT_W = $clog2(N_ACCESS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] index_val,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  mem_cycles,
    output logic              carry_flag,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    logic              load;
    logic              cap;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] src_op;

    add_exec_ea #(.ADDR_W(ADDR_W)) u_ea (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base(dst_base), .index(index_val), .ea(ea)
    );

    add_exec_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .src_ptr(src_ptr), .ea(ea),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .load(load), .cap(cap),
        .src_op(src_op), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .busy(busy), .done(done), .mem_cycles(mem_cycles)
    );

    add_exec_sum #(.DATA_W(DATA_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .cap(cap),
        .op_a(src_op), .op_b(mem_rdata), .sum(mem_wdata), .carry(carry_flag)
    );

    AST_WR_AT_EA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == ea)); // R6
endmodule

// File: tb/test_add_exec_seq.sv
module test_add_exec_seq;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] dst_base = '0, src_ptr = '0, index_val = '0;
    logic          busy, done, carry_flag, mem_re, mem_we;
    logic [2:0]    mem_cycles;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;

    add_exec_seq #(.ADDR_W(AW), .DATA_W(DW)) i_add_exec_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base),
        .src_ptr(src_ptr), .index_val(index_val), .busy(busy), .done(done),
        .mem_cycles(mem_cycles), .carry_flag(carry_flag), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Memory model with a programmable read latency and an access log.
    logic [DW-1:0] mem [256];
    int            lat = 0;
    int            wcnt = 0;
    logic [AW-1:0] last_addr = '0;
    bit            hold_err = 0;
    bit            log_w [16];
    logic [AW-1:0] log_a [16];
    logic [DW-1:0] log_d [16];
    int            log_n = 0;

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (log_n < 16) begin
                log_w[log_n] = 1; log_a[log_n] = mem_addr; log_d[log_n] = mem_wdata;
            end
            log_n++;
            wcnt = 0;
        end else if (mem_re) begin
            if (wcnt > 0 && mem_addr != last_addr) hold_err = 1;
            last_addr = mem_addr;
            if (wcnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr];
                if (log_n < 16) begin
                    log_w[log_n] = 0; log_a[log_n] = mem_addr; log_d[log_n] = mem[mem_addr];
                end
                log_n++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // Vector table: base, index, pointer location, source address, source value, destination value, latency.
    localparam logic [AW-1:0] V_BASE [NV] = '{8'h10, 8'hF0, 8'h20, 8'h30, 8'h70};
    localparam logic [AW-1:0] V_IDX  [NV] = '{8'h05, 8'h20, 8'h00, 8'hFF, 8'h0A};
    localparam logic [AW-1:0] V_PTR  [NV] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h44};
    localparam logic [AW-1:0] V_SADR [NV] = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h64};
    localparam logic [DW-1:0] V_SVAL [NV] = '{16'h0003, 16'hFFFF, 16'h1234, 16'h8000, 16'h00FF};
    localparam logic [DW-1:0] V_DVAL [NV] = '{16'h0004, 16'h0002, 16'h4321, 16'h8000, 16'h0F01};
    localparam int            V_LAT  [NV] = '{0, 1, 3, 2, 0};

    task automatic run_one(input logic [AW-1:0] base, idx, ptr, sadr,
                           input logic [DW-1:0] sval, dval, input int l, input bit poke);
        logic [AW-1:0] ea;
        logic [DW:0]   wide;
        int            guard;
        ea   = base + idx;
        wide = {1'b0, sval} + {1'b0, dval};
        mem[ptr]  = {8'hA5, sadr};   // upper bits must be ignored
        mem[sadr] = sval;
        mem[ea]   = dval;
        lat = l; log_n = 0; hold_err = 0;
        dst_base = base; index_val = idx; src_ptr = ptr;
        start = 1'b1; tick(); start = 1'b0;
        if (poke) begin
            tick();
            dst_base = 8'h00; index_val = 8'h01; src_ptr = 8'h02; start = 1'b1;
            tick(); start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 200) begin tick(); guard++; end
        check(done, "R10 done seen", done, 1);
        check(mem_cycles == 3'd4, "R10 cycle count", mem_cycles, 4);
        check(log_n == 4, "R11 access count", log_n, 4);
        check(!log_w[0] && log_a[0] == ptr, "R3 pointer read", log_a[0], ptr);
        check(!log_w[1] && log_a[1] == sadr, "R4 source read", log_a[1], sadr);
        check(!log_w[2] && log_a[2] == ea, "R2 R5 destination read", log_a[2], ea);
        check(log_w[3] && log_a[3] == ea, "R6 write address", log_a[3], ea);
        check(log_d[3] == wide[DW-1:0], "R6 write data", log_d[3], wide[DW-1:0]);
        check(mem[ea] == wide[DW-1:0], "R6 memory result", mem[ea], wide[DW-1:0]);
        check(carry_flag == wide[DW], "R7 carry flag", carry_flag, wide[DW]);
        check(!hold_err, "R8 read address held", hold_err, 0);
        tick();
        check(!done && !busy, "R10 done one cycle", {done, busy}, 0);
        tick(); tick();
        check(log_n == 4, "R9 R11 no extra access", log_n, 4);
        check(carry_flag == wide[DW], "R7 carry held", carry_flag, wide[DW]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        tick(); tick();
        check(!busy && !done && !mem_re && !mem_we && mem_cycles == 0 && !carry_flag,
              "R1 reset state", {busy, done, mem_re, mem_we, carry_flag}, 0);
        rst_n = 1'b1;
        tick();
        check(!busy && !mem_re && !mem_we && mem_cycles == 0, "R1 after release",
              {busy, mem_re, mem_we}, 0);

        for (int v = 0; v < NV; v++)
            run_one(V_BASE[v], V_IDX[v], V_PTR[v], V_SADR[v], V_SVAL[v], V_DVAL[v], V_LAT[v], 1'b0);

        // R11: start pulsed while busy, with different inputs.
        run_one(8'h50, 8'h03, 8'h45, 8'h65, 16'h0101, 16'h0202, 1, 1'b1);

        // R1: reset in mid-sequence leaves memory untouched.
        mem[8'h45] = 16'h0065; mem[8'h65] = 16'h0007; mem[8'h58] = 16'h0009;
        lat = 4; log_n = 0;
        dst_base = 8'h50; index_val = 8'h08; src_ptr = 8'h45;
        start = 1'b1; tick(); start = 1'b0;
        tick(); tick();
        rst_n = 1'b0; tick();
        check(!busy && !mem_re && !mem_we && !done && mem_cycles == 0, "R1 mid-run reset",
              {busy, mem_re, mem_we, done}, 0);
        rst_n = 1'b1; tick(); tick();
        check(mem[8'h58] == 16'h0009 && !busy, "R1 no write after reset", mem[8'h58], 16'h0009);

        // Sequence after reset still works.
        run_one(8'hFF, 8'h01, 8'h46, 8'h66, 16'h7FFF, 16'h0001, 0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule